// File: doc/BRIEF.md
# 8x8 Two-Pass Inverse Integer Transform

This block turns an 8x8 tile of signed 16-bit transform coefficients into an 8x8 tile of signed 16-bit residuals for a video decoder. It applies an 8-point integer inverse transform in two passes. The first pass works down each column and keeps its results in an internal tile store. The second pass then works across each row of that store, so the results come out in raster order. Each 8-point transform splits into two halves. An even half combines inputs 0, 2, 4 and 6, and an odd half combines inputs 1, 3, 5 and 7. Output k is the even term plus the odd term, and output 7-k is the even term minus the odd term.

A caller places the whole tile on `coef_in` and pulses `start` for one cycle. `col_limit` tells the block how far non-zero coefficients extend across the columns. When it is below 4, the first pass skips the four right-hand columns. The result is on `res_out` when `done` pulses, and it stays there until the next accepted start.

Top module: `idct8x8_butterfly`

## Requirements
- R1: While reset is held and after it is released, `busy` and `done` are low and no transform runs until `start` is seen.
- R2: Tile element i lies in bits [16*i+15:16*i] of `coef_in` and `res_out`, with i = 8*row + column. The result is the column pass followed by the row pass of the 8-point transform. The even terms use the weights 64, 83 and 36. The odd terms use the weights 89, 75, 50 and 18. Each pass rounds by adding 2^(s-1) and then shifts right arithmetically by s, with s = 7 after the column pass and s = 12 after the row pass.
- R3: Each pass saturates its rounded result to the range -32768..32767.
- R4: When `col_limit` is below 4, the column pass is not applied to columns 4..7. Those entries go into the row pass with their raw coefficient values. A tile whose columns 4..7 are zero therefore gives the same result as the full computation. A `col_limit` of 4 or more runs all eight columns.
- R5: `done` is a one-cycle pulse. It rises 16 clock edges after the edge that accepts `start`, or 12 edges after it when the right half is skipped.
- R6: A `start` that arrives while `busy` is high is ignored, and the tile in progress completes unchanged.
- R7: While idle with no `start`, `res_out` holds the last result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept `coef_in` and `col_limit` and begin a tile |
| col_limit | input | 4 | Column extent hint; below 4 skips the right-half column pass |
| coef_in | input | 1024 | 64 signed 16-bit coefficients in raster order |
| busy | output | 1 | Tile in progress |
| done | output | 1 | One-cycle pulse: `res_out` holds a new result |
| res_out | output | 1024 | 64 signed 16-bit residuals in raster order |

## Verification
The assertions assume that `start` is a clean one-cycle request sampled on rising edges. They also assume that `coef_in` and `col_limit` are settled when `start` is high; nothing else is sampled later. The stimulus changes inputs only on falling edges and holds `start` for a single cycle. It raises `start` during a busy tile only on purpose, to exercise R6, and then changes the coefficients so that any wrong capture would show. The skip cases use hints of 2 and 3, with the right half both zero and non-zero, and use 4 as the boundary where no skip occurs.

// File: rtl/idct8x8_butterfly.sv
module idct8x8_butterfly #(
  parameter int DW  = 16,
  parameter int AW  = 32,
  parameter int SH1 = 7,
  parameter int SH2 = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [3:0]      col_limit,
  input  logic [64*DW-1:0] coef_in,
  output logic            busy,
  output logic            done,
  output logic [64*DW-1:0] res_out
);
  localparam int N = 8;
  localparam logic signed [AW-1:0] VMAX = AW'((1 << (DW-1)) - 1);
  localparam logic signed [AW-1:0] VMIN = -VMAX - 1;

  typedef logic [N-1:0][DW-1:0] vec_t;

  logic [63:0][DW-1:0] tile;
  logic       pass_row, skip_r;
  logic [2:0] idx;
  vec_t       in_v, out_v;

  function automatic logic [DW-1:0] rsat(input logic signed [AW-1:0] v, input int sh);
    logic signed [AW-1:0] rnd, r;
    rnd = AW'(1) <<< (sh - 1);
    r   = (v + rnd) >>> sh;
    if (r > VMAX) r = VMAX;
    else if (r < VMIN) r = VMIN;
    return r[DW-1:0];
  endfunction

  function automatic vec_t tr8(input vec_t s, input int sh);
    logic signed [AW-1:0] x [N];
    logic signed [AW-1:0] ev [4];
    logic signed [AW-1:0] od [4];
    logic signed [AW-1:0] a0, a1, b0, b1;
    vec_t y;
    for (int k = 0; k < N; k++) x[k] = AW'($signed(s[k]));
    a0 = 64 * (x[0] + x[4]);
    a1 = 64 * (x[0] - x[4]);
    b0 = 83 * x[2] + 36 * x[6];
    b1 = 36 * x[2] - 83 * x[6];
    ev[0] = a0 + b0;
    ev[1] = a1 + b1;
    ev[2] = a1 - b1;
    ev[3] = a0 - b0;
    od[0] = 89 * x[1] + 75 * x[3] + 50 * x[5] + 18 * x[7];
    od[1] = 75 * x[1] - 18 * x[3] - 89 * x[5] - 50 * x[7];
    od[2] = 50 * x[1] - 89 * x[3] + 18 * x[5] + 75 * x[7];
    od[3] = 18 * x[1] - 50 * x[3] + 75 * x[5] - 89 * x[7];
    for (int k = 0; k < 4; k++) begin
      y[k]     = rsat(ev[k] + od[k], sh);
      y[N-1-k] = rsat(ev[k] - od[k], sh);
    end
    return y;
  endfunction

  always_comb begin
    for (int k = 0; k < N; k++)
      in_v[k] = pass_row ? tile[{idx, 3'(k)}] : tile[{3'(k), idx}];
  end

  assign out_v   = tr8(in_v, pass_row ? SH2 : SH1);
  assign res_out = tile;

  wire last_col = (idx == (skip_r ? 3'd3 : 3'd7));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile     <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      pass_row <= 1'b0;
      skip_r   <= 1'b0;
      idx      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          tile     <= coef_in;
          busy     <= 1'b1;
          pass_row <= 1'b0;
          skip_r   <= (col_limit < 4'd4);
          idx      <= '0;
        end
      end else begin
        for (int k = 0; k < N; k++) begin
          if (pass_row) tile[{idx, 3'(k)}] <= out_v[k];
          else          tile[{3'(k), idx}] <= out_v[k];
        end
        if (!pass_row) begin
          if (last_col) begin
            pass_row <= 1'b1;
            idx      <= '0;
          end else idx <= idx + 3'd1;
        end else begin
          if (idx == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
          idx <= idx + 3'd1;
        end
      end
    end
  end

  logic [4:0] lat_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (!busy && start) lat_cnt <= '0;
    else if (busy) lat_cnt <= lat_cnt + 5'd1;
  end

  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r5_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == (skip_r ? 5'd12 : 5'd16)));
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(pass_row && idx == 3'd7)) |=> busy && (lat_cnt == $past(lat_cnt) + 5'd1));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(res_out));
endmodule

// File: tb/tb_idct8x8_butterfly.sv
module tb_idct8x8_butterfly;
  logic clk = 0, rst_n = 0, start = 0;
  logic [3:0] col_limit = 0;
  logic [1023:0] coef_in = '0;
  logic busy, done;
  logic [1023:0] res_out;

  always #2 clk = ~clk;

  idct8x8_butterfly dut (.clk(clk), .rst_n(rst_n), .start(start), .col_limit(col_limit),
    .coef_in(coef_in), .busy(busy), .done(done), .res_out(res_out));

  int checks = 0, failures = 0;
  int cin [64];
  logic [1023:0] exp_q [$];
  logic [1023:0] last_exp;
  bit finished = 0;

  localparam int BASIS [64] = '{
    64, 64, 64, 64, 64, 64, 64, 64,
    89, 75, 50, 18,-18,-50,-75,-89,
    83, 36,-36,-83,-83,-36, 36, 83,
    75,-18,-89,-50, 50, 89, 18,-75,
    64,-64,-64, 64, 64,-64,-64, 64,
    50,-89, 18, 75,-75,-18, 89,-50,
    36,-83, 83,-36,-36, 83,-83, 36,
    18,-50, 75,-89, 89,-75, 50,-18};

  function automatic int clip(input longint v, input int s);
    longint r;
    r = (v + (longint'(1) << (s - 1))) >>> s;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic logic [1023:0] model(input int col);
    int m [64];
    int t [64];
    logic [1023:0] p;
    for (int i = 0; i < 64; i++) m[i] = cin[i];
    for (int c = 0; c < 8; c++) begin
      if (c < 4 || col >= 4) begin
        for (int n = 0; n < 8; n++) begin
          longint acc = 0;
          for (int k = 0; k < 8; k++) acc += longint'(BASIS[k*8+n]) * m[k*8+c];
          t[n*8+c] = clip(acc, 7);
        end
      end else
        for (int n = 0; n < 8; n++) t[n*8+c] = m[n*8+c];
    end
    for (int r = 0; r < 8; r++)
      for (int n = 0; n < 8; n++) begin
        longint acc = 0;
        for (int k = 0; k < 8; k++) acc += longint'(BASIS[k*8+n]) * t[r*8+k];
        p[16*(r*8+n) +: 16] = 16'(clip(acc, 12));
      end
    return p;
  endfunction

  function automatic logic [1023:0] pack();
    logic [1023:0] p;
    for (int i = 0; i < 64; i++) p[16*i +: 16] = 16'(cin[i]);
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expected tiles when done pulses (R2, R3, R4, R6)
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) check(0, "R5 unexpected done", 1, 0);
      else begin
        logic [1023:0] e;
        int bad;
        e = exp_q.pop_front();
        bad = -1;
        for (int i = 63; i >= 0; i--) if (res_out[16*i +: 16] !== e[16*i +: 16]) bad = i;
        if (bad < 0) check(1, "R2 tile", 0, 0);
        else check(0, $sformatf("R2/R3/R4/R6 tile element %0d", bad),
                   $signed(res_out[16*bad +: 16]), $signed(e[16*bad +: 16]));
      end
    end
  end

  task automatic run(input int col, input int ref_col, input bit poke, input string tag);
    logic [1023:0] e;
    int k, lat;
    e = model(ref_col);
    exp_q.push_back(e);
    last_exp = e;
    lat = (col < 4) ? 13 : 17;
    @(negedge clk);
    coef_in = pack();
    col_limit = 4'(col);
    start = 1;
    @(negedge clk);
    start = 0;
    k = 1;
    while (!done && k < 40) begin
      start = poke && (k == 3);
      if (poke && k == 3) coef_in = ~coef_in;
      @(negedge clk);
      k++;
    end
    start = 0;
    check(k == lat, {"R5 latency ", tag}, k, lat);
    @(negedge clk);
    check(!done, "R5 done one cycle", done, 0);
  endtask

  task automatic fill(input int lo, input int hi, input bit zero_right);
    for (int i = 0; i < 64; i++) begin
      cin[i] = lo + int'($urandom_range(0, hi - lo));
      if (zero_right && (i % 8) >= 4) cin[i] = 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !busy, "R1 in reset", {done, busy}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!done && !busy, "R1 after reset", {done, busy}, 0);

    for (int i = 0; i < 64; i++) cin[i] = 0;
    cin[0] = 4096;
    run(8, 8, 0, "dc");
    fill(-256, 255, 0);   run(8, 8, 0, "small R2");
    fill(-4000, 4000, 0); run(8, 8, 0, "mid R2");
    fill(-32768, 32767, 0); run(8, 8, 0, "full R3");
    for (int i = 0; i < 64; i++) cin[i] = 32767;
    run(8, 8, 0, "max R3");
    for (int i = 0; i < 64; i++) cin[i] = ((i % 3) == 0) ? -32768 : 32767;
    run(8, 8, 0, "mixed R3");
    fill(-2000, 2000, 1); run(3, 8, 0, "R4 skip zero right equals full");
    fill(-2000, 2000, 1); run(0, 8, 0, "R4 skip limit 0");
    fill(-2000, 2000, 0); run(2, 2, 0, "R4 skip raw right");
    fill(-2000, 2000, 0); run(4, 4, 0, "R4 boundary no skip");
    fill(-3000, 3000, 0); run(8, 8, 1, "R6 start while busy");
    fill(-3000, 3000, 0); run(3, 3, 1, "R6 start while busy skip");
    repeat (6) @(negedge clk);
    check(res_out === last_exp, "R7 hold while idle", res_out[15:0], last_exp[15:0]);
    check(exp_q.size() == 0, "R5 all results seen", exp_q.size(), 0);
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule